// File: doc/BRIEF.md
# Selectable-Phase Peak Detector With Threshold Interrupt

This block watches the signed voltage and current samples of up to three line phases. A 3-bit enable field chooses which phases it monitors. Each sample is reduced to an 8-bit magnitude: the top byte of its absolute value. That magnitude is compared against one voltage limit and one current limit. Any monitored sample above its limit raises a sticky flag, which a separate strobe clears. Interrupt logic outside the block is expected to use these flags.

The block also keeps one running maximum for voltage and one for current. A window is a programmable number of half-line-cycle strobes. When a window closes, each running maximum moves into a peak register that software can read, and the running maximum starts again from zero. Producing the samples and holding the threshold and window registers are handled elsewhere.

Top module: `phase_peak_det`

## Requirements
- R1: A sample's magnitude is bits [23:16] of its 24-bit two's-complement absolute value. The most negative code gives 0x80, and -1 gives 0x00.
- R2: In the cycle after a valid voltage sample on an enabled phase whose magnitude exceeds `v_thr`, `v_flag` reads 1.
- R3: In the cycle after a valid current sample on an enabled phase whose magnitude exceeds `i_thr`, `i_flag` reads 1.
- R4: Bit k of `phase_en` enables phase k (k = 0..2). Samples on phases whose bit is 0 affect neither the flags nor the peaks.
- R5: Once set, a flag stays set until `flag_clr` is pulsed. If a new exceedance arrives in the same cycle as the clear, the flag stays set.
- R6: A magnitude equal to its threshold does not set the flag.
- R7: A window ends on the `half_cyc` strobe that brings the strobe count to `win_len`. A `win_len` of 0 acts as 1. In the next cycle each peak register holds the largest magnitude seen in that window, including samples that arrive in the closing cycle. The next window's maximum starts from 0.
- R8: After reset both flags and both peak registers are 0. The peak registers change only when a window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| v_smp | input | 3x24 | Per-phase signed voltage samples |
| v_vld | input | 3 | Per-phase voltage sample valid |
| i_smp | input | 3x24 | Per-phase signed current samples |
| i_vld | input | 3 | Per-phase current sample valid |
| half_cyc | input | 1 | One-cycle strobe at each half-line cycle |
| phase_en | input | 3 | Phase monitoring enable, bit k = phase k |
| v_thr | input | 8 | Voltage peak threshold |
| i_thr | input | 8 | Current peak threshold |
| win_len | input | 16 | Window length in half-line cycles |
| flag_clr | input | 1 | Clears both sticky flags |
| v_flag | output | 1 | Voltage threshold exceeded (sticky) |
| i_flag | output | 1 | Current threshold exceeded (sticky) |
| v_peak | output | 8 | Largest voltage magnitude of the last closed window |
| i_peak | output | 8 | Largest current magnitude of the last closed window |

## Verification
The hardest case to reach from the ports is a window that closes in the same cycle that a new, larger sample arrives. It matters because that closing sample must reach the peak register even though the running maximum is being cleared in that same cycle. The stimulus first flushes everything gathered during the threshold vectors through a one-strobe window. It then runs a three-strobe window in which the largest sample coincides with the closing strobe, and finally an empty window that must read back zero.

// File: rtl/ppd_pkg.sv
`timescale 1ns/1ps
package ppd_pkg;
  localparam int MAG_W = 8;
  typedef logic [MAG_W-1:0] mag_t;

  function automatic mag_t max_mag(input mag_t a, input mag_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ppd_mag.sv
`timescale 1ns/1ps
module ppd_mag #(
  parameter int NPH   = 3,
  parameter int SMP_W = 24,
  parameter int MAG_W = 8
) (
  input  logic [NPH-1:0][SMP_W-1:0] smp,
  input  logic [NPH-1:0]            vld,
  input  logic [NPH-1:0]            en,
  output logic [NPH-1:0][MAG_W-1:0] mag,
  output logic [NPH-1:0]            qual
);
  localparam int TOP = SMP_W - 1;

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    logic [SMP_W-1:0] absval;
    assign absval  = smp[k][TOP] ? (~smp[k] + 1'b1) : smp[k];
    assign qual[k] = vld[k] & en[k];
    assign mag[k]  = qual[k] ? absval[TOP -: MAG_W] : '0;
  end
endmodule

// File: rtl/ppd_win.sv
`timescale 1ns/1ps
module ppd_win #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_cyc,
  input  logic [CNT_W-1:0] win_len,
  output logic             win_end
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt} + 1'b1;
  assign win_end  = half_cyc && (next_cnt >= {1'b0, win_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (win_end)  cnt <= '0;
    else if (half_cyc) cnt <= next_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/ppd_chan.sv
`timescale 1ns/1ps
module ppd_chan #(
  parameter int NPH   = 3,
  parameter int MAG_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPH-1:0][MAG_W-1:0] mag,
  input  logic [NPH-1:0]            qual,
  input  logic [MAG_W-1:0]          thr,
  input  logic                      flag_clr,
  input  logic                      win_end,
  output logic                      hit,
  output logic                      flag,
  output logic [MAG_W-1:0]          peak
);
  import ppd_pkg::*;

  logic [NPH-1:0]   over;
  logic [MAG_W-1:0] cyc_max;
  logic [MAG_W-1:0] run_max;
  logic [MAG_W-1:0] win_max;

  for (genvar k = 0; k < NPH; k++) begin : g_cmp
    assign over[k] = qual[k] && (mag[k] > thr);
  end
  assign hit = |over;

  always_comb begin
    cyc_max = '0;
    for (int k = 0; k < NPH; k++) cyc_max = max_mag(cyc_max, mag[k]);
  end
  assign win_max = max_mag(run_max, cyc_max);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag    <= 1'b0;
      run_max <= '0;
      peak    <= '0;
    end else begin
      flag <= hit | (flag & ~flag_clr);
      if (win_end) begin
        peak    <= win_max;
        run_max <= '0;
      end else begin
        run_max <= win_max;
      end
    end
  end
endmodule

// File: rtl/phase_peak_det.sv
`timescale 1ns/1ps
module phase_peak_det #(
  parameter int NPH   = 3,
  parameter int SMP_W = 24,
  parameter int MAG_W = ppd_pkg::MAG_W,
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPH-1:0][SMP_W-1:0] v_smp,
  input  logic [NPH-1:0]            v_vld,
  input  logic [NPH-1:0][SMP_W-1:0] i_smp,
  input  logic [NPH-1:0]            i_vld,
  input  logic                      half_cyc,
  input  logic [NPH-1:0]            phase_en,
  input  logic [MAG_W-1:0]          v_thr,
  input  logic [MAG_W-1:0]          i_thr,
  input  logic [CNT_W-1:0]          win_len,
  input  logic                      flag_clr,
  output logic                      v_flag,
  output logic                      i_flag,
  output logic [MAG_W-1:0]          v_peak,
  output logic [MAG_W-1:0]          i_peak
);
  logic [NPH-1:0][MAG_W-1:0] v_mag, i_mag;
  logic [NPH-1:0]            v_qual, i_qual;
  logic                      v_hit, i_hit, win_end;

  ppd_mag #(.NPH(NPH), .SMP_W(SMP_W), .MAG_W(MAG_W)) u_vmag (
    .smp(v_smp), .vld(v_vld), .en(phase_en), .mag(v_mag), .qual(v_qual));

  ppd_mag #(.NPH(NPH), .SMP_W(SMP_W), .MAG_W(MAG_W)) u_imag (
    .smp(i_smp), .vld(i_vld), .en(phase_en), .mag(i_mag), .qual(i_qual));

  ppd_win #(.CNT_W(CNT_W)) u_win (
    .clk(clk), .rst_n(rst_n), .half_cyc(half_cyc), .win_len(win_len),
    .win_end(win_end));

  ppd_chan #(.NPH(NPH), .MAG_W(MAG_W)) u_vchan (
    .clk(clk), .rst_n(rst_n), .mag(v_mag), .qual(v_qual), .thr(v_thr),
    .flag_clr(flag_clr), .win_end(win_end), .hit(v_hit), .flag(v_flag),
    .peak(v_peak));

  ppd_chan #(.NPH(NPH), .MAG_W(MAG_W)) u_ichan (
    .clk(clk), .rst_n(rst_n), .mag(i_mag), .qual(i_qual), .thr(i_thr),
    .flag_clr(flag_clr), .win_end(win_end), .hit(i_hit), .flag(i_flag),
    .peak(i_peak));
endmodule

// File: rtl/ppd_checker.sv
`timescale 1ns/1ps
module ppd_checker #(
  parameter int NPH   = 3,
  parameter int MAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flag_clr,
  input logic [NPH-1:0]   phase_en,
  input logic             v_hit,
  input logic             i_hit,
  input logic             win_end,
  input logic             v_flag,
  input logic             i_flag,
  input logic [MAG_W-1:0] v_peak,
  input logic [MAG_W-1:0] i_peak
);
  AST_VHIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    v_hit |=> v_flag); // R2
  AST_IHIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    i_hit |=> i_flag); // R3
  AST_HIT_NEEDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (v_hit || i_hit) |-> (phase_en != '0)); // R4
  AST_VFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (v_flag && !flag_clr) |=> v_flag); // R5
  AST_IFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (i_flag && !flag_clr) |=> i_flag); // R5
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !v_hit && !i_hit) |=> (!v_flag && !i_flag)); // R5
  AST_PEAK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> ($stable(v_peak) && $stable(i_peak))); // R8
endmodule

bind phase_peak_det ppd_checker #(.NPH(NPH), .MAG_W(MAG_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .phase_en(phase_en),
  .v_hit(v_hit), .i_hit(i_hit), .win_end(win_end), .v_flag(v_flag),
  .i_flag(i_flag), .v_peak(v_peak), .i_peak(i_peak));

// File: tb/test_phase_peak_det.sv
`timescale 1ns/1ps
module test_phase_peak_det;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0][23:0] v_smp, i_smp;
  logic [2:0] v_vld, i_vld, phase_en;
  logic half_cyc, flag_clr;
  logic [7:0] v_thr, i_thr;
  logic [15:0] win_len;
  logic v_flag, i_flag;
  logic [7:0] v_peak, i_peak;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  phase_peak_det i_phase_peak_det (
    .clk(clk), .rst_n(rst_n), .v_smp(v_smp), .v_vld(v_vld), .i_smp(i_smp),
    .i_vld(i_vld), .half_cyc(half_cyc), .phase_en(phase_en), .v_thr(v_thr),
    .i_thr(i_thr), .win_len(win_len), .flag_clr(flag_clr), .v_flag(v_flag),
    .i_flag(i_flag), .v_peak(v_peak), .i_peak(i_peak));

  typedef struct packed {
    logic [1:0]  ph;
    logic [2:0]  en;
    logic [23:0] v;
    logic [23:0] i;
    logic [7:0]  vt;
    logic [7:0]  it;
    logic        ev;
    logic        ei;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 3'b001, 24'h120000, 24'h050000, 8'h10, 8'h10, 1'b1, 1'b0},
    '{2'd1, 3'b010, 24'hD00000, 24'h7F0000, 8'h30, 8'h40, 1'b0, 1'b1},
    '{2'd2, 3'b011, 24'h7FFFFF, 24'h7FFFFF, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd2, 3'b100, 24'h800000, 24'hFF0001, 8'h7F, 8'h00, 1'b1, 1'b0},
    '{2'd0, 3'b111, 24'h00FFFF, 24'hFFFFFF, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd1, 3'b101, 24'h400000, 24'h400000, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd0, 3'b111, 24'hC10000, 24'h3F0000, 8'h3E, 8'h3F, 1'b1, 1'b0},
    '{2'd1, 3'b111, 24'h010000, 24'h000000, 8'h00, 8'h00, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle();
    v_vld = '0; i_vld = '0; half_cyc = 1'b0; flag_clr = 1'b0;
  endtask

  task automatic put(input int ph, input logic [23:0] v, input logic [23:0] i);
    v_smp = '0; i_smp = '0;
    v_smp[ph] = v; i_smp[ph] = i;
    v_vld = '0; i_vld = '0;
    v_vld[ph] = 1'b1; i_vld[ph] = 1'b1;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    v_smp = '0; i_smp = '0; phase_en = 3'b111; v_thr = 8'hFF; i_thr = 8'hFF;
    win_len = 16'hFFFF;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset v_flag", {7'd0, v_flag}, 8'd0);
    chk("R8 reset i_flag", {7'd0, i_flag}, 8'd0);
    chk("R8 reset v_peak", v_peak, 8'd0);
    chk("R8 reset i_peak", i_peak, 8'd0);

    // R1 R2 R3 R4 R6: table of single-sample vectors, each after a clear
    foreach (VEC[n]) begin
      flag_clr = 1'b1;
      @(negedge clk);
      idle();
      phase_en = VEC[n].en; v_thr = VEC[n].vt; i_thr = VEC[n].it;
      put(int'(VEC[n].ph), VEC[n].v, VEC[n].i);
      @(negedge clk);
      idle();
      chk($sformatf("R2 vec %0d v_flag", n), {7'd0, v_flag}, {7'd0, VEC[n].ev});
      chk($sformatf("R3 vec %0d i_flag", n), {7'd0, i_flag}, {7'd0, VEC[n].ei});
    end

    // R5: sticky while idle
    repeat (3) @(negedge clk);
    chk("R5 sticky v_flag", {7'd0, v_flag}, 8'd1);
    // R5: clear and new exceedance in the same cycle
    phase_en = 3'b111; v_thr = 8'h00; flag_clr = 1'b1;
    put(0, 24'h010000, 24'h000000);
    @(negedge clk);
    idle();
    chk("R5 clear with hit", {7'd0, v_flag}, 8'd1);
    flag_clr = 1'b1;
    @(negedge clk);
    idle();
    chk("R5 clear v_flag", {7'd0, v_flag}, 8'd0);
    chk("R5 clear i_flag", {7'd0, i_flag}, 8'd0);
    chk("R8 peak held before window end", v_peak, 8'd0);

    // R7: win_len 0 acts as 1; flush everything gathered so far
    win_len = 16'd0; half_cyc = 1'b1;
    @(negedge clk);
    idle();
    chk("R7 flush v_peak", v_peak, 8'h80);
    chk("R4 R7 flush i_peak", i_peak, 8'h7F);

    // R7: three half-cycle window, biggest sample on the closing strobe
    win_len = 16'd3; v_thr = 8'hFF; i_thr = 8'hFF;
    put(0, 24'h200000, 24'h000000); half_cyc = 1'b1;
    @(negedge clk); idle();
    put(1, 24'hB00000, 24'h000000);
    @(negedge clk); idle();
    half_cyc = 1'b1;
    @(negedge clk); idle();
    chk("R8 v_peak held mid-window", v_peak, 8'h80);
    put(2, 24'h600000, 24'h110000); half_cyc = 1'b1;
    @(negedge clk); idle();
    chk("R7 window v_peak", v_peak, 8'h60);
    chk("R7 window i_peak", i_peak, 8'h11);

    // R7: empty window restarts from zero
    repeat (3) begin
      half_cyc = 1'b1;
      @(negedge clk); idle();
    end
    chk("R7 empty window v_peak", v_peak, 8'h00);
    chk("R7 empty window i_peak", i_peak, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule